// File: doc/BRIEF.md
# Software-Released Receive Byte Queue

This block keeps the bytes that arrive from a serial receiver in a byte queue and shows them to software through a window of memory-mapped words. Software reads as many words as it needs out of the window. The oldest unread byte always sits at the first window word. Reading does not consume anything. Bytes leave the queue only when software writes a release count to a control register. This lets a driver copy a block of data first and release it afterwards in one write.

The fill level is published in a status word. Two request lines are derived from it:

- A data-ready request rises once the fill reaches a power-of-two trigger level.
- An idle-data request rises once unread bytes have waited a programmed number of character-time units without any traffic.

Bytes that arrive while the queue is full are dropped and reported. Bytes flagged by the receiver as damaged are still stored and reported.

Top module: `rxq_window`

## Requirements
- R1: After reset the fill level is 0, both requests and both report pulses are low, and the trigger code, divisor and idle limit registers read 0.
- R2: Accepted bytes are kept in arrival order. A read of the window word at byte address 0x004+4m (m from 0 to 254) returns the queued bytes 4m to 4m+3, counted from the oldest unread byte, with the oldest of the four in bits 7:0. Read data is valid the cycle after the read strobe.
- R3: The status word at address 0x000 carries fill bits 7:0 in bits 31:24 and fill bits 9:8 in bits 7:6. All other bits are 0.
- R4: The queue holds at most 1023 bytes. A byte offered while the queue holds 1023 is dropped, the fill stays 1023, and `overrun` pulses high for one cycle.
- R5: Writing N in bits 9:0 of address 0x800 releases the min(N, fill) oldest bytes. The next unread byte becomes the first window byte, and the read position never passes the write position.
- R6: The trigger code is held in bits 22:20 of address 0x808 and reads back there. `data_req` is high, one cycle after the fill changes, exactly when fill ≥ 4·2^code bytes.
- R7: The divisor B is held in bits 15:0 of address 0x810 and the idle limit T in bits 15:0 of address 0x814; both read back. With B and T nonzero and the fill nonzero, `tmo_req` rises exactly T·B·4 clock edges after the last restart event.
- R8: A restart event is an accepted byte or any write to address 0x800. A restart event clears `tmo_req` and the idle count, and so does an empty queue. `tmo_req` is a separate line from `data_req`.
- R9: A byte accepted with `rx_err` high is stored like any other byte, and `line_err` pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receiver offers a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receiver marks the byte as damaged |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| data_req | output | 1 | Fill has reached the trigger level |
| tmo_req | output | 1 | Unread data has been idle for the programmed time |
| overrun | output | 1 | One-cycle pulse: a byte was dropped at full |
| line_err | output | 1 | One-cycle pulse: a flagged byte was stored |

## Verification
The assertions check four properties on every cycle:

- The gap between the write and read positions always equals the published fill.
- The read position never advances by more than the fill it had.
- A drop is reported only when the queue was full.
- The idle request is never raised on an empty queue, and it stays up until a restart event.

Only the bench scenarios can show the following:

- The byte order and lane placement seen through the window after unaligned releases and pointer wrap.
- The split layout of the fill in the status word.
- The exact edge on which the idle request rises for a given divisor and limit.
- The trigger thresholds of the individual codes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int QAW = 10;
  localparam logic [11:0] ADR_STAT = 12'h000;
  localparam logic [11:0] ADR_FREE = 12'h800;
  localparam logic [11:0] ADR_CONF = 12'h808;
  localparam logic [11:0] ADR_DIV  = 12'h810;
  localparam logic [11:0] ADR_IDLE = 12'h814;

  function automatic logic [QAW:0] trig_level(input logic [2:0] code);
    return (QAW+1)'(4) << code;
  endfunction

  function automatic logic [31:0] stat_word(input logic [QAW-1:0] f);
    logic [31:0] w;
    w = '0;
    w[31:24] = f[7:0];
    w[7:6]   = f[9:8];
    return w;
  endfunction
endpackage

// File: rtl/rxq_lane_ram.sv
module rxq_lane_ram #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << IW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          rel_we,
  input  logic [AW-1:0] rel_n,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] fill,
  output logic          accept
);
  localparam logic [AW-1:0] CAP = {AW{1'b1}};
  logic [AW-1:0] take;

  assign accept = push && (fill != CAP);
  assign take   = !rel_we ? '0 : ((rel_n > fill) ? fill : rel_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      rd_ptr <= rd_ptr + take;
      if (accept) wr_ptr <= wr_ptr + AW'(1);
      fill <= fill - take + AW'(accept);
    end
  end

  assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) == fill);
  assert_no_overtake_R5: assert property (@(posedge clk) disable iff (rst)
    AW'(rd_ptr - $past(rd_ptr)) <= $past(fill));
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  localparam int PRE_W = DIV_W + 2;
  logic [PRE_W-1:0] pre, pre_top;
  logic [CNT_W-1:0] ticks;
  logic             enabled;

  assign pre_top = {div, 2'b00} - PRE_W'(1);
  assign enabled = (div != '0) && (limit != '0);

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      pre   <= '0;
      ticks <= '0;
      fire  <= 1'b0;
    end else if (enabled && !fire) begin
      if (pre == pre_top) begin
        pre   <= '0;
        ticks <= ticks + CNT_W'(1);
        if (ticks + CNT_W'(1) == limit) fire <= 1'b1;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && !restart && active) |=> fire);
endmodule

// File: rtl/rxq_window.sv
module rxq_window
  import rxq_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_err,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        data_req,
  output logic        tmo_req,
  output logic        overrun,
  output logic        line_err
);
  localparam int AW = QAW;
  localparam int IW = AW - 2;
  localparam logic [AW-1:0] CAP = {AW{1'b1}};

  logic [AW-1:0]    rd_ptr, wr_ptr, fill, win_off, win_start;
  logic             accept, rel_we, win_hit;
  logic [2:0]       trig_code;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] idle_q;
  logic [7:0]       lane_q [4];
  logic [1:0]       rot_q;
  logic             win_q;
  logic [31:0]      reg_q, reg_mux, win_word;

  assign rel_we    = bus_wr && (bus_addr == ADR_FREE);
  assign win_hit   = bus_rd && (bus_addr[11:10] == 2'b00) && (bus_addr[9:2] != '0);
  assign win_off   = AW'({bus_addr[9:2], 2'b00}) - AW'(4);
  assign win_start = rd_ptr + win_off;

  rxq_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .push(rx_valid), .rel_we(rel_we),
    .rel_n(bus_wdata[AW-1:0]), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .fill(fill), .accept(accept)
  );

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [1:0]    j_off;
    logic [AW-1:0] pos;
    assign j_off = 2'(b) - win_start[1:0];
    assign pos   = win_start + AW'(j_off);
    rxq_lane_ram #(.IW(IW)) u_ram (
      .clk(clk), .we(accept && (wr_ptr[1:0] == 2'(b))),
      .waddr(wr_ptr[AW-1:2]), .wdata(rx_data),
      .re(win_hit), .raddr(pos[AW-1:2]), .rdata(lane_q[b])
    );
  end

  rxq_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(accept || rel_we),
    .active(fill != '0), .div(div_q), .limit(idle_q), .fire(tmo_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_code <= '0;
      div_q     <= '0;
      idle_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_CONF) trig_code <= bus_wdata[22:20];
      if (bus_addr == ADR_DIV)  div_q     <= bus_wdata[DIV_W-1:0];
      if (bus_addr == ADR_IDLE) idle_q    <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_STAT: reg_mux = stat_word(fill);
      ADR_CONF: reg_mux = {9'b0, trig_code, 20'b0};
      ADR_DIV:  reg_mux = 32'(div_q);
      ADR_IDLE: reg_mux = 32'(idle_q);
      default:  reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      rot_q <= '0;
      reg_q <= '0;
    end else if (bus_rd) begin
      win_q <= win_hit;
      rot_q <= win_start[1:0];
      reg_q <= reg_mux;
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++) win_word[8*j +: 8] = lane_q[2'(rot_q + 2'(j))];
  end
  assign bus_rdata = win_q ? win_word : reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_req <= 1'b0;
      overrun  <= 1'b0;
      line_err <= 1'b0;
    end else begin
      data_req <= ({1'b0, fill} >= trig_level(trig_code));
      overrun  <= rx_valid && !accept;
      line_err <= accept && rx_err;
    end
  end

  assert_drop_only_full_R4: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ($past(fill) == CAP));
  assert_tmo_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
    tmo_req |-> (fill != '0));
  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(overrun && line_err));
endmodule

// File: tb/tb_rxq_window.sv
module tb_rxq_window;
  import rxq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_err = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic data_req, tmo_req, overrun, line_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] mq[$];
  logic [2:0] code_m = '0;
  logic       ovr_seen, lerr_seen;

  always #2 clk = ~clk;

  rxq_window dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .data_req(data_req), .tmo_req(tmo_req),
    .overrun(overrun), .line_err(line_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] exp_stat(input int n);
    logic [9:0] f;
    f = 10'(n);
    return {f[7:0], 16'h0, f[9:8], 6'h0};
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    return {mq[k+3], mq[k+2], mq[k+1], mq[k]};
  endfunction

  task automatic push(input logic [7:0] d, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
    ovr_seen = overrun; lerr_seen = line_err;
    if (mq.size() < 1023) mq.push_back(d);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic release_n(input int n);
    int take;
    wr(ADR_FREE, 32'(n));
    take = (n > mq.size()) ? mq.size() : n;
    repeat (take) void'(mq.pop_front());
  endtask

  task automatic check_req(input string req);
    @(negedge clk);
    check(req, 32'(data_req), 32'(mq.size() >= (4 << code_m)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    check("R1 data_req", 32'(data_req), 0);
    check("R1 tmo_req", 32'(tmo_req), 0);
    check("R1 overrun", 32'(overrun), 0);
    rd(ADR_STAT, d); check("R1 status", d, 0);
    rd(ADR_CONF, d); check("R1 conf", d, 0);
    rd(ADR_DIV, d);  check("R1 div", d, 0);
    rd(ADR_IDLE, d); check("R1 idle", d, 0);

    // R2 directed order and lanes
    for (int i = 0; i < 9; i++) push(8'(8'h10 + i), 1'b0);
    rd(12'h004, d); check("R2 word0", d, 32'h13121110);
    rd(12'h008, d); check("R2 word1", d, 32'h17161514);
    // R5 unaligned release shifts window
    release_n(3);
    rd(12'h004, d); check("R5 shifted", d, exp_word(0));
    rd(ADR_STAT, d); check("R3 status 6", d, exp_stat(6));
    // R5 clamp
    release_n(1000);
    rd(ADR_STAT, d); check("R5 clamp empty", d, 0);
    for (int i = 0; i < 4; i++) push(8'(8'hA0 + i), 1'b0);
    rd(12'h004, d); check("R5 after clamp", d, 32'hA3A2A1A0);
    // R9 flagged byte stored
    push(8'h5C, 1'b1);
    check("R9 line_err", 32'(lerr_seen), 1);
    rd(12'h004, d);
    rd(12'h008, d); check("R9 stored", 32'(d[7:0]), 32'h5C);
    release_n(1023);

    // R6 trigger levels
    wr(ADR_CONF, 32'(3'd1) << 20); code_m = 3'd1;
    rd(ADR_CONF, d); check("R6 readback", d, 32'h0010_0000);
    for (int i = 0; i < 7; i++) push(8'(i), 1'b0);
    check_req("R6 below 8");
    push(8'h77, 1'b0);
    check_req("R6 at 8");
    release_n(1);
    check_req("R6 after release");

    // R7 / R8 idle timing, B=2 T=3 -> 24 edges
    release_n(1023);
    wr(ADR_DIV, 32'd2); wr(ADR_IDLE, 32'd3);
    rd(ADR_DIV, d); check("R7 div readback", d, 2);
    push(8'h01, 1'b0);
    repeat (23) @(negedge clk);
    check("R7 before limit", 32'(tmo_req), 0);
    @(negedge clk);
    check("R7 at limit", 32'(tmo_req), 1);
    check("R8 separate", 32'(data_req), 0);
    push(8'h02, 1'b0);
    check("R8 byte clears", 32'(tmo_req), 0);
    repeat (24) @(negedge clk);
    check("R7 rearmed", 32'(tmo_req), 1);
    wr(ADR_FREE, 32'd0);
    check("R8 release clears", 32'(tmo_req), 0);
    release_n(1023);
    repeat (40) @(negedge clk);
    check("R8 empty stays low", 32'(tmo_req), 0);
    wr(ADR_IDLE, 32'd0);

    // random phase
    code_m = 3'd3; wr(ADR_CONF, 32'(3'd3) << 20);
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op < 2) begin
        int n;
        n = 1 + int'($urandom % 40);
        for (int i = 0; i < n; i++) push(8'($urandom), 1'b0);
      end else if (op == 2) begin
        release_n(int'($urandom % 70));
      end else if (mq.size() >= 4) begin
        int m;
        m = int'($urandom % (mq.size() / 4));
        if (m > 254) m = 254;
        rd(12'(4 + 4*m), d); check("R2 random window", d, exp_word(4*m));
      end
      rd(ADR_STAT, d); check("R3 random status", d, exp_stat(mq.size()));
      check_req("R6 random");
    end

    // R4 full and drop
    while (mq.size() < 1023) push(8'($urandom), 1'b0);
    rd(ADR_STAT, d); check("R3 full status", d, 32'hFF0000C0);
    push(8'hEE, 1'b0);
    check("R4 overrun", 32'(ovr_seen), 1);
    rd(ADR_STAT, d); check("R4 fill kept", d, 32'hFF0000C0);
    rd(12'h3FC, d); check("R4 last word", d, exp_word(1016));
    release_n(1023);
    rd(ADR_STAT, d); check("R5 drained", d, 0);

    finish_run();
  end
endmodule